// File: doc/BRIEF.md
# Single-Path Bit Crosspoint Router

This block is a purely combinational crosspoint. It takes one bit from an 8-bit input bus and places it on one bit of an 8-bit output bus. A packed 7-bit route code makes both choices. Every output line that is not the chosen destination sits at logic 1, so the output bus idles high.

The route code has three fields. The low three bits name the source bit of the input bus. The next three bits name the destination bit of the output bus. The top bit is spare and has no effect. The datapath is an N:1 source multiplexer feeding a 1:M destination decoder whose idle outputs are forced high. There is no clock, register or enable anywhere in the path, so the destination line follows its source line as soon as the logic settles. Because nothing flows as a stream, the block has no valid/ready handshake.

Both bus widths are parameters. The route code is log2(N)+log2(M)+1 bits wide, with the spare bit on top. The default is N = M = 8.

Top module: `bit_xpoint_router`

## Requirements
- R1: Route-code bits [2:0], read as an unsigned number s, pick input bit s as the routed value.
- R2: Route-code bits [5:3], read as an unsigned number d, pick output bit d, which carries the routed value.
- R3: Every output bit other than bit d reads 1. At most one output bit can therefore read 0 at any time.
- R4: The path is combinational. A change on the selected input bit appears on the destination output without any clock edge.
- R5: Route-code bit [6] has no effect. Two codes that differ only in bit 6 give identical outputs for the same input.
- R6: Input bits other than bit s have no effect on the output.
- R7: For example, route code 9 (s = 1, d = 1) with input bit 1 at 0 gives output 8'hFD.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_bus_i | input | 8 | Input bus; one bit of it is routed |
| route_i | input | 7 | Route code: [2:0] source index, [5:3] destination index, [6] spare |
| dst_bus_o | output | 8 | Output bus; idles at 1 except the destination line |

## Verification
The bench sweeps all 128 route codes against several input patterns, with the source bit set to 0 in some patterns and 1 in others. A router that swapped the two fields, or that let the destination idle low, would show a wrong output word. Separate checks repeat a route with bit 6 flipped and with every non-source input bit inverted. A design that decoded the spare bit, or that mixed other inputs into the path, would change the output there. A final check holds the route code fixed and toggles only the source bit. A latched or clocked path would then lag behind the input.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  // Width of an index into a bus of n lines (at least 1 bit).
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/xpt_route_split.sv
module xpt_route_split #(
  parameter int SRC_W = 3,
  parameter int DST_W = 3,
  parameter int SEL_W = SRC_W + DST_W + 1
) (
  input  logic [SEL_W-1:0] route_i,
  output logic [SRC_W-1:0] src_idx_o,
  output logic [DST_W-1:0] dst_idx_o
);
  localparam int USED_W = SRC_W + DST_W;

  assign src_idx_o = route_i[SRC_W-1:0];
  assign dst_idx_o = route_i[SRC_W +: DST_W];

  // The spare top bits (R5) drive nothing.
  generate
    if (SEL_W > USED_W) begin : g_spare
      logic unused_spare;
      assign unused_spare = ^route_i[SEL_W-1:USED_W];
    end
  endgenerate
endmodule

// File: rtl/xpt_src_mux.sv
module xpt_src_mux #(
  parameter int N_IN  = 8,
  parameter int SRC_W = 3
) (
  input  logic [N_IN-1:0]  data_i,
  input  logic [SRC_W-1:0] src_idx_i,
  output logic             bit_o
);
  // AND-OR multiplexer: one-hot match per line. An index outside the bus yields 0.
  logic [N_IN-1:0] hit;

  genvar gi;
  generate
    for (gi = 0; gi < N_IN; gi++) begin : g_hit
      assign hit[gi] = data_i[gi] & (src_idx_i == SRC_W'(gi));
    end
  endgenerate

  assign bit_o = |hit;

  // R1: the routed value is the indexed input bit
  always_comb begin
    if (int'(src_idx_i) < N_IN)
      p_src_pick_r1: assert (bit_o == data_i[src_idx_i])
        else $error("routed bit does not match indexed input");
  end
endmodule

// File: rtl/xpt_dst_dec.sv
module xpt_dst_dec #(
  parameter int N_OUT = 8,
  parameter int DST_W = 3
) (
  input  logic             bit_i,
  input  logic [DST_W-1:0] dst_idx_i,
  output logic [N_OUT-1:0] bus_o
);
  // Each line idles high and takes the routed bit only when addressed.
  genvar gj;
  generate
    for (gj = 0; gj < N_OUT; gj++) begin : g_line
      assign bus_o[gj] = (dst_idx_i == DST_W'(gj)) ? bit_i : 1'b1;
    end
  endgenerate

  // R2: the addressed line carries the routed bit
  always_comb begin
    if (int'(dst_idx_i) < N_OUT)
      p_dst_carry_r2: assert (bus_o[dst_idx_i] == bit_i)
        else $error("destination line does not carry routed bit");
  end

  // R3: every other line reads 1
  always_comb begin
    for (int k = 0; k < N_OUT; k++) begin
      if (DST_W'(k) != dst_idx_i)
        p_idle_high_r3: assert (bus_o[k] == 1'b1)
          else $error("idle line %0d not high", k);
    end
  end

  // R3: at most one line low
  always_comb begin
    p_one_low_max_r3: assert ($countones(~bus_o) <= 1)
      else $error("more than one output line low");
  end
endmodule

// File: rtl/bit_xpoint_router.sv
module bit_xpoint_router #(
  parameter int N_IN  = 8,
  parameter int N_OUT = 8,
  parameter int SEL_W = xpt_pkg::idx_width(N_IN) + xpt_pkg::idx_width(N_OUT) + 1
) (
  input  logic [N_IN-1:0]  src_bus_i,
  input  logic [SEL_W-1:0] route_i,
  output logic [N_OUT-1:0] dst_bus_o
);
  localparam int SRC_W = xpt_pkg::idx_width(N_IN);
  localparam int DST_W = xpt_pkg::idx_width(N_OUT);

  logic [SRC_W-1:0] src_idx;
  logic [DST_W-1:0] dst_idx;
  logic             routed_bit;

  xpt_route_split #(.SRC_W(SRC_W), .DST_W(DST_W), .SEL_W(SEL_W)) u_split (
    .route_i   (route_i),
    .src_idx_o (src_idx),
    .dst_idx_o (dst_idx)
  );

  xpt_src_mux #(.N_IN(N_IN), .SRC_W(SRC_W)) u_mux (
    .data_i    (src_bus_i),
    .src_idx_i (src_idx),
    .bit_o     (routed_bit)
  );

  xpt_dst_dec #(.N_OUT(N_OUT), .DST_W(DST_W)) u_dec (
    .bit_i     (routed_bit),
    .dst_idx_i (dst_idx),
    .bus_o     (dst_bus_o)
  );
endmodule

// File: tb/tb_bit_xpoint_router.sv
module tb_bit_xpoint_router;
  logic       clk = 1'b0;
  logic [7:0] a;
  logic [6:0] sel;
  logic [7:0] b;
  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz, pacing only

  bit_xpoint_router dut (.src_bus_i(a), .route_i(sel), .dst_bus_o(b));

  // {route code, input, expected output}
  localparam int NV = 12;
  localparam logic [22:0] VEC [NV] = '{
    {7'd9,   8'hFD, 8'hFD},  // R7
    {7'd0,   8'h00, 8'hFE},
    {7'd7,   8'h7F, 8'hFE},
    {7'd63,  8'h7F, 8'h7F},
    {7'd56,  8'hFE, 8'h7F},
    {7'd73,  8'hFD, 8'hFD},
    {7'd127, 8'h7F, 8'h7F},
    {7'd21,  8'hDF, 8'hFB},
    {7'd21,  8'h20, 8'hFF},
    {7'd42,  8'hFB, 8'hDF},
    {7'd100, 8'hEF, 8'hEF},
    {7'd8,   8'h00, 8'hFD}
  };

  function automatic logic [7:0] model(input logic [6:0] s, input logic [7:0] d);
    logic [7:0] r = 8'hFF;
    r[s[5:3]] = d[s[2:0]];
    return r;
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: route=%0d in=%h got=%h expected=%h", req, sel, a, got, exp);
    end
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: cycles=%0d expected<=20000", cycles);
      finish_up();
    end
  end

  initial begin
    logic [7:0] b0;
    logic [7:0] pats [4] = '{8'h00, 8'hFF, 8'hA5, 8'h3C};
    a = 8'h00; sel = 7'd0;
    @(negedge clk);
    check("R3 initial", b, 8'hFE);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      {sel, a} = VEC[i][22:8];
      @(negedge clk);
      check("R1/R2/R3 table", b, VEC[i][7:0]);
    end

    // Full sweep of route codes
    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 128; s++) begin
        sel = 7'(s); a = pats[p] ^ 8'(s * 37);
        @(negedge clk);
        check("R1/R2/R3 sweep", b, model(sel, a));
      end
    end

    // R5: spare bit flipped
    for (int s = 0; s < 64; s++) begin
      sel = 7'(s); a = 8'(s * 11 + 5);
      @(negedge clk); b0 = b;
      sel = 7'(s) | 7'h40;
      @(negedge clk);
      check("R5 spare bit", b, b0);
    end

    // R6: non-source inputs inverted
    for (int s = 0; s < 64; s += 9) begin
      sel = 7'(s); a = 8'h96;
      @(negedge clk); b0 = b;
      a = a ^ ~(8'h01 << s[2:0]);
      @(negedge clk);
      check("R6 other inputs", b, b0);
    end

    // R4: source toggles show without a clock edge
    sel = 7'd42; a = 8'hFF;
    @(negedge clk);
    for (int t = 0; t < 4; t++) begin
      a[2] = ~a[2];
      #0.5;
      check("R4 combinational follow", b, {2'b11, a[2], 5'b11111});
    end

    finish_up();
  end
endmodule